// File: doc/BRIEF.md
# Load-Delay Slot Register Usage Classifier

This block inspects the instruction that sits in the delay slot behind a pending load and reports how that instruction uses the register the load is about to write. The inputs are the load's 5-bit destination index, the 32-bit delay-slot instruction word and a valid strobe. The output is a registered 2-bit usage code with a valid flag. The code says whether the slot instruction reads that register, writes it, does both, or does not touch it.

Decoding covers the integer subset of the 32-bit three-operand instruction set. That subset includes the register-register group selected by the function field, the register-immediate branch group selected by the rt field, and the coprocessor move forms. A pipeline controller uses the code to decide what to do with the old and new register values across the slot. The act of stalling or forwarding belongs to that controller, not to this block.

Instruction fields used below: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0].

Top module: `ld_slot_classify`

## Requirements
- R1: `valid_o` equals `valid_i` from one clock earlier. `code_o` is 0 whenever `valid_o` is low. Both outputs are 0 during and right after reset.
- R2: The code values are 1 for read-and-write, 2 for read only, 3 for write only and 0 for no use. When a source field and a destination field both match, the result is 1. Read is tested before write.
- R3: An all-zero instruction word always gives 0, for any register index.
- R4: For opcode 0, the constant right shifts (function 0x02, 0x03) read rt and write rd. The variable shifts (0x04, 0x06, 0x07) and the ALU ops (0x20–0x27, 0x2A, 0x2B) read rs and rt and write rd.
- R5: For opcode 0, functions 0x10 and 0x12 only write rd. Functions 0x11, 0x13, 0x08 and 0x09 only read rs. Functions 0x18–0x1B only read rs and rt.
- R6: Opcode 0x03 gives 3 when the index is 31 and 0 otherwise. Opcode 0x02 always gives 0.
- R7: Opcodes 0x04 and 0x05 read rs and rt, and opcodes 0x06 and 0x07 read rs. Opcode 0x01 reads rs when rt is 0x00, 0x01, 0x10 or 0x11, and gives 0 for any other rt value.
- R8: Opcodes 0x08–0x0E and the loads 0x20, 0x21, 0x23, 0x24 and 0x25 read rs and write rt. Opcode 0x0F only writes rt.
- R9: For the partial-word loads (0x22, 0x26), a match on rt gives 3 before rs is checked. A match on rs alone gives 2. Code 1 is never produced for these opcodes.
- R10: The stores 0x28, 0x29, 0x2A, 0x2B and 0x2E read rs and rt. Opcodes 0x32 and 0x3A read rs only.
- R11: For opcodes 0x10 and 0x12, an rs value of 0x00 or 0x02 writes rt. An rs value of 0x04 or 0x06 reads rt. Any other rs value gives 0.
- R12: Opcode and function values not named above give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Query strobe |
| ld_reg_i | input | 5 | Destination index of the pending load |
| instr_i | input | 32 | Delay-slot instruction word |
| valid_o | output | 1 | Result valid, one cycle after the strobe |
| code_o | output | 2 | Usage code: 0 none, 1 both, 2 read, 3 write |

## Verification
The block holds no state across queries beyond one output register. A wrong decode or a wrong priority therefore appears on `code_o` in the cycle right after the offending strobe. No later query can hide it.

A reference model in the bench classifies every query independently. The bench compares its result against the ports on every clock, across a directed set of field-overlap cases and a long run of queries that are biased so the fields often equal the load index. A misplaced field slice or a swapped priority shows up as a code mismatch on the first query that exercises it.

// File: rtl/lds_pkg.sv
package lds_pkg;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OP_W    = 6;

  // field slots compared against the load index
  localparam int unsigned F_RS  = 0;
  localparam int unsigned F_RT  = 1;
  localparam int unsigned F_RD  = 2;
  localparam int unsigned NUM_F = 3;

  typedef enum logic [1:0] {
    HZ_NONE  = 2'd0,
    HZ_BOTH  = 2'd1,
    HZ_READ  = 2'd2,
    HZ_WRITE = 2'd3
  } hz_code_e;

  typedef struct packed {
    logic rs_rd;
    logic rt_rd;
    logic rt_wr;
    logic rd_wr;
    logic lnk_wr;
    logic wr_first;
  } use_t;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'h00;
  localparam logic [OP_W-1:0] OP_REGIMM  = 6'h01;
  localparam logic [OP_W-1:0] OP_J       = 6'h02;
  localparam logic [OP_W-1:0] OP_JAL     = 6'h03;
  localparam logic [OP_W-1:0] OP_LUI     = 6'h0F;
  localparam logic [OP_W-1:0] OP_COP0    = 6'h10;
  localparam logic [OP_W-1:0] OP_COP2    = 6'h12;
  localparam logic [OP_W-1:0] OP_LWL     = 6'h22;
  localparam logic [OP_W-1:0] OP_LWR     = 6'h26;
endpackage

// File: rtl/lds_decode.sv
module lds_decode
  import lds_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output use_t               use_o
);
  logic [OP_W-1:0]  op;
  logic [5:0]       fn;
  logic [REG_W-1:0] sub_rs, sub_rt;

  assign op     = instr_i[31:26];
  assign fn     = instr_i[5:0];
  assign sub_rs = instr_i[25:21];
  assign sub_rt = instr_i[20:16];

  always_comb begin
    use_o = '0;
    if (instr_i != '0) begin
      case (op)
        OP_SPECIAL: begin
          case (fn)
            6'h02, 6'h03: begin
              use_o.rt_rd = 1'b1;
              use_o.rd_wr = 1'b1;
            end
            6'h04, 6'h06, 6'h07,
            6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
            6'h2A, 6'h2B: begin
              use_o.rs_rd = 1'b1;
              use_o.rt_rd = 1'b1;
              use_o.rd_wr = 1'b1;
            end
            6'h10, 6'h12: use_o.rd_wr = 1'b1;
            6'h11, 6'h13, 6'h08, 6'h09: use_o.rs_rd = 1'b1;
            6'h18, 6'h19, 6'h1A, 6'h1B: begin
              use_o.rs_rd = 1'b1;
              use_o.rt_rd = 1'b1;
            end
            default: ;
          endcase
        end
        OP_REGIMM: begin
          if (sub_rt == 5'h00 || sub_rt == 5'h01 ||
              sub_rt == 5'h10 || sub_rt == 5'h11)
            use_o.rs_rd = 1'b1;
        end
        OP_JAL: use_o.lnk_wr = 1'b1;
        6'h04, 6'h05: begin
          use_o.rs_rd = 1'b1;
          use_o.rt_rd = 1'b1;
        end
        6'h06, 6'h07: use_o.rs_rd = 1'b1;
        6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E,
        6'h20, 6'h21, 6'h23, 6'h24, 6'h25: begin
          use_o.rs_rd = 1'b1;
          use_o.rt_wr = 1'b1;
        end
        OP_LUI: use_o.rt_wr = 1'b1;
        OP_LWL, OP_LWR: begin
          use_o.rs_rd    = 1'b1;
          use_o.rt_wr    = 1'b1;
          use_o.wr_first = 1'b1;
        end
        6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2E: begin
          use_o.rs_rd = 1'b1;
          use_o.rt_rd = 1'b1;
        end
        6'h32, 6'h3A: use_o.rs_rd = 1'b1;
        OP_COP0, OP_COP2: begin
          case (sub_rs)
            5'h00, 5'h02: use_o.rt_wr = 1'b1;
            5'h04, 5'h06: use_o.rt_rd = 1'b1;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lds_match.sv
module lds_match
  import lds_pkg::*;
#(
  parameter int unsigned LINK_REG = 31
) (
  input  logic [REG_W-1:0]   ld_reg_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  use_t               use_i,
  output hz_code_e           code_o
);
  localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

  logic [REG_W-1:0] fld [NUM_F];
  logic [NUM_F-1:0] hit;
  logic             rd_hit, wr_hit;

  assign fld[F_RS] = instr_i[25:21];
  assign fld[F_RT] = instr_i[20:16];
  assign fld[F_RD] = instr_i[15:11];

  for (genvar i = 0; i < NUM_F; i++) begin : g_cmp
    assign hit[i] = (fld[i] == ld_reg_i);
  end

  assign rd_hit = (use_i.rs_rd & hit[F_RS]) | (use_i.rt_rd & hit[F_RT]);
  assign wr_hit = (use_i.rt_wr & hit[F_RT]) | (use_i.rd_wr & hit[F_RD]) |
                  (use_i.lnk_wr & (ld_reg_i == LINK_IDX));

  always_comb begin
    if (use_i.wr_first) begin
      // partial-word loads merge into rt: write wins
      if (wr_hit)      code_o = HZ_WRITE;
      else if (rd_hit) code_o = HZ_READ;
      else             code_o = HZ_NONE;
    end else begin
      if (rd_hit && wr_hit) code_o = HZ_BOTH;
      else if (rd_hit)      code_o = HZ_READ;
      else if (wr_hit)      code_o = HZ_WRITE;
      else                  code_o = HZ_NONE;
    end
  end
endmodule

// File: rtl/ld_slot_classify.sv
module ld_slot_classify
  import lds_pkg::*;
#(
  parameter int unsigned LINK_REG = 31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [REG_W-1:0]   ld_reg_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               valid_o,
  output logic [1:0]         code_o
);
  use_t     use_w;
  hz_code_e code_w;
  logic     valid_q;
  hz_code_e code_q;
  logic     armed_q;

  lds_decode u_dec (
    .instr_i (instr_i),
    .use_o   (use_w)
  );

  lds_match #(.LINK_REG(LINK_REG)) u_match (
    .ld_reg_i (ld_reg_i),
    .instr_i  (instr_i),
    .use_i    (use_w),
    .code_o   (code_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      code_q  <= HZ_NONE;
      armed_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      code_q  <= valid_i ? code_w : HZ_NONE;
      armed_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign code_o  = code_q;

  logic [OP_W-1:0] op_w;
  assign op_w = instr_i[31:26];

  assert_valid_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> valid_o == $past(valid_i));

  assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> code_o == 2'd0);

  assert_nop_none_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(valid_i && instr_i == '0)) |-> code_o == 2'd0);

  assert_jump_none_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(valid_i && op_w == OP_J)) |-> code_o == 2'd0);

  assert_link_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(valid_i && op_w == OP_JAL)) |->
      code_o == (($past(ld_reg_i) == REG_W'(LINK_REG)) ? 2'd3 : 2'd0));

  assert_partial_no_both_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(valid_i && (op_w == OP_LWL || op_w == OP_LWR))) |-> code_o != 2'd1);

  assert_store_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(valid_i && (op_w == 6'h28 || op_w == 6'h29 || op_w == 6'h2A ||
                                  op_w == 6'h2B || op_w == 6'h2E))) |->
      (code_o == 2'd0 || code_o == 2'd2));
endmodule

// File: tb/ld_slot_classify_test.sv
`timescale 1ns/1ps
module ld_slot_classify_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  ld_reg = '0;
  logic [31:0] instr = '0;
  logic        valid_o;
  logic [1:0]  code_o;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ld_slot_classify uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .ld_reg_i(ld_reg), .instr_i(instr),
    .valid_o(valid_o), .code_o(code_o)
  );

  function automatic int cls(bit rd, bit wr);
    if (rd && wr) return 1;
    if (rd) return 2;
    if (wr) return 3;
    return 0;
  endfunction

  // behavioural reference, written per opcode class
  function automatic int ref_code(int r, logic [31:0] w);
    int op, fn, rsv, rtv;
    bit s, t, d;
    op = int'(w[31:26]); fn = int'(w[5:0]);
    rsv = int'(w[25:21]); rtv = int'(w[20:16]);
    s = (rsv == r); t = (rtv == r); d = (int'(w[15:11]) == r);
    if (w == 32'd0) return 0;
    case (op) inside
      0: case (fn) inside
           2, 3: return cls(t, d);
           4, 6, 7, [32:39], 42, 43: return cls(s || t, d);
           16, 18: return cls(0, d);
           8, 9, 17, 19: return cls(s, 0);
           [24:27]: return cls(s || t, 0);
           default: return 0;
         endcase
      1: return (rtv == 0 || rtv == 1 || rtv == 16 || rtv == 17) ? cls(s, 0) : 0;
      3: return (r == 31) ? 3 : 0;
      4, 5: return cls(s || t, 0);
      6, 7: return cls(s, 0);
      [8:14], 32, 33, 35, 36, 37: return cls(s, t);
      15: return cls(0, t);
      34, 38: return t ? 3 : (s ? 2 : 0);
      40, 41, 42, 43, 46: return cls(s || t, 0);
      50, 58: return cls(s, 0);
      16, 18: case (rsv)
                0, 2: return cls(0, t);
                4, 6: return cls(t, 0);
                default: return 0;
              endcase
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] rw(int op, int rs, int rt, int rd, int fn);
    return {op[5:0], rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction

  task automatic check(string tag, logic v_exp, int c_exp);
    n_run++;
    if (valid_o !== v_exp || int'(code_o) != c_exp) begin
      n_fail++;
      $display("FAIL %s: valid=%0b code=%0d expected valid=%0b code=%0d",
               tag, valid_o, code_o, v_exp, c_exp);
    end
  endtask

  task automatic step(string tag, logic v, int r, logic [31:0] w, int exp);
    @(negedge clk);
    valid_i = v; ld_reg = r[4:0]; instr = w;
    @(posedge clk); #1;
    check(tag, v, v ? exp : 0);
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", 1'b0, 0);

    step("R3 nop reg0", 1, 0, 32'd0, 0);
    step("R2 both", 1, 5, rw(0, 5, 1, 5, 6'h21), 1);
    step("R4 alu write", 1, 5, rw(0, 1, 2, 5, 6'h21), 3);
    step("R4 alu read rt", 1, 5, rw(0, 1, 5, 3, 6'h22), 2);
    step("R4 shift rs unused", 1, 7, rw(0, 7, 1, 2, 6'h02), 0);
    step("R4 shift both", 1, 7, rw(0, 0, 7, 7, 6'h03), 1);
    step("R4 var shift rs", 1, 7, rw(0, 7, 1, 2, 6'h06), 2);
    step("R5 mfhi", 1, 9, rw(0, 0, 0, 9, 6'h10), 3);
    step("R5 mtlo", 1, 9, rw(0, 9, 0, 0, 6'h13), 2);
    step("R5 jalr rd", 1, 9, rw(0, 3, 0, 9, 6'h09), 0);
    step("R5 div", 1, 9, rw(0, 1, 9, 9, 6'h1A), 2);
    step("R6 jal r31", 1, 31, rw(3, 31, 31, 31, 0), 3);
    step("R6 jal r30", 1, 30, rw(3, 30, 30, 30, 0), 0);
    step("R6 j", 1, 31, rw(2, 31, 31, 31, 0), 0);
    step("R7 beq rt", 1, 4, rw(4, 1, 4, 0, 0), 2);
    step("R7 bgtz rt", 1, 4, rw(7, 1, 4, 0, 0), 0);
    step("R7 regimm 0x10", 1, 4, rw(1, 4, 16, 0, 0), 2);
    step("R7 regimm other", 1, 4, rw(1, 4, 2, 0, 0), 0);
    step("R8 addiu both", 1, 6, rw(9, 6, 6, 0, 0), 1);
    step("R8 lw write", 1, 6, rw(35, 1, 6, 0, 0), 3);
    step("R8 lui write", 1, 6, rw(15, 0, 6, 0, 0), 3);
    step("R8 lui rs", 1, 6, rw(15, 6, 1, 0, 0), 0);
    step("R9 lwl both fields", 1, 8, rw(34, 8, 8, 0, 0), 3);
    step("R9 lwr rs", 1, 8, rw(38, 8, 1, 0, 0), 2);
    step("R10 sw rt", 1, 10, rw(43, 1, 10, 0, 0), 2);
    step("R10 sb rs", 1, 10, rw(40, 10, 1, 0, 0), 2);
    step("R10 lwc2 rt", 1, 10, rw(50, 1, 10, 0, 0), 0);
    step("R10 swc2 rs", 1, 10, rw(58, 10, 1, 0, 0), 2);
    step("R11 mfc0", 1, 11, rw(16, 0, 11, 0, 0), 3);
    step("R11 mtc2", 1, 11, rw(18, 4, 11, 0, 0), 2);
    step("R11 cop0 other", 1, 11, rw(16, 16, 11, 11, 0), 0);
    step("R12 sll", 1, 12, rw(0, 12, 12, 12, 6'h00), 0);
    step("R12 syscall", 1, 12, rw(0, 12, 12, 12, 6'h0C), 0);
    step("R12 op 0x3F", 1, 12, rw(63, 12, 12, 12, 0), 0);
    step("R1 idle", 0, 5, rw(0, 5, 5, 5, 6'h21), 0);

    for (int k = 0; k < 3000; k++) begin
      int r, op, rs, rt, rd, fn;
      logic v;
      logic [31:0] w;
      r  = $urandom_range(0, 31);
      op = $urandom_range(0, 63);
      rs = ($urandom_range(0, 1) == 1) ? r : $urandom_range(0, 31);
      rt = ($urandom_range(0, 1) == 1) ? r : $urandom_range(0, 31);
      rd = ($urandom_range(0, 1) == 1) ? r : $urandom_range(0, 31);
      fn = $urandom_range(0, 63);
      if ($urandom_range(0, 3) == 0) op = 0;
      if ($urandom_range(0, 7) == 0) op = 16 + 2 * $urandom_range(0, 1);
      if (op == 16 || op == 18) rs = 2 * $urandom_range(0, 3);
      w = rw(op, rs, rt, rd, fn);
      if ($urandom_range(0, 49) == 0) w = 32'd0;
      v = ($urandom_range(0, 9) != 0);
      step("R2 sweep", v, r, w, ref_code(r, w));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule